// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the management-bus master for an external Ethernet PHY. It runs one register read or one register write at a time over the two-wire MDC/MDIO link. The host side is a plain synchronous write port with two targets: a 16-bit data register and a combined address/command word. Writing the command word with its start bit set launches a transaction. The `busy` output stays high until the last frame bit has gone out. After a read, the value the PHY returned appears on `rd_data`.

The block derives MDC from the system clock. A 3-bit range code in the command word selects the divide ratio, and the code should be chosen so that MDC falls between about 1 and 2.5 MHz. System clocks below 25 MHz are not supported. Each frame is 64 MDC periods long and is sent MSB first:

- 32 preamble ones
- start code `01`
- opcode: `10` for a read, `01` for a write
- 5-bit PHY address
- 5-bit register number
- 2-bit turnaround
- 16 data bits

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, `busy`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.
- R2: A command write with bit 0 (start) set and `busy` low raises `busy` on the next clock edge. `busy` stays high for exactly one 64-bit frame and then falls. A command write with start clear starts nothing.
- R3: The command field at bits [4:2] selects the MDC period in system clocks: 0→16, 1→26, 2→42, 3→62, 4→102. The codes 5, 6 and 7 also give 102. MDC is low for the first half of each period and high for the second half.
- R4: For a write (bit 1 = 1), MDIO carries, MSB first: 32 ones, `01`, `01`, the PHY address from bits [14:10], the register number from bits [9:5], `10`, and then the data register. The whole frame is driven (`mdio_oe` = 1).
- R5: For a read (bit 1 = 0), the header is the same except that the opcode is `10`. `mdio_oe` is 0 from the first turnaround bit (frame bit 46) to the end of the frame.
- R6: During a read, `mdio_i` is sampled on each MDC rising edge of frame bits 48–63, MSB first. The 16-bit result is in `rd_data` in the same cycle that `busy` falls.
- R7: `mdio_o` changes only while MDC is low (after a falling edge). It is stable across each rising edge and throughout the high phase.
- R8: A command write while `busy` is high is ignored. The running frame, its divider and its opcode are unchanged, and no second transaction follows.
- R9: Whenever `busy` is low, `mdc` is 0 and `mdio_oe` is 0.
- R10: A data-register write is visible on `rd_data` on the next cycle, and it supplies the data bits of the next write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 15 | Command word: [14:10] PHY, [9:5] register, [4:2] range code, [1] write, [0] start |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Data register write value |
| busy | output | 1 | High while a transaction is in progress |
| rd_data | output | 16 | Data register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable (0 = released) |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
A bench-side PHY model records every MDC rising edge and drives read data after falling edges. Each frame, turnaround pattern, divider period and result is checked against values the driver queued. The bench covers all five divide ratios and an out-of-range code. A divider off by one would show a wrong rise-to-rise period, and a release point shifted by one bit would show in the `mdio_oe` pattern.

A command issued mid-frame must leave the frame intact; a design that accepted it would corrupt the header or finish twice. A command with start clear must not launch anything. A sampling-edge or bit-order error would scramble the returned word. An off-by-one in the bit counter would end `busy` a bit early or late.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int DATA_BITS  = 16;
    localparam int ADDR_BITS  = 5;
    localparam int CODE_BITS  = 3;
    localparam int HALF_W     = 6;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int TA_BIT     = PRE_BITS + 4 + 2 * ADDR_BITS;   // 46
    localparam int DATA_BIT   = TA_BIT + 2;                     // 48

    typedef struct packed {
        logic [ADDR_BITS-1:0] phy;
        logic [ADDR_BITS-1:0] regad;
        logic [CODE_BITS-1:0] range_code;
        logic                 wr;
        logic                 start;
    } mgmt_cmd_t;

    // half of the MDC period, in system clocks
    function automatic logic [HALF_W-1:0] half_period(input logic [CODE_BITS-1:0] code);
        case (code)
            3'd0:    return HALF_W'(8);
            3'd1:    return HALF_W'(13);
            3'd2:    return HALF_W'(21);
            3'd3:    return HALF_W'(31);
            default: return HALF_W'(51);
        endcase
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c,
                                                          input logic [DATA_BITS-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        op = c.wr ? 2'b01 : 2'b10;
        ta = c.wr ? 2'b10 : 2'b11;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise_tick,
    output logic              fall_tick
);
    logic [HALF_W-1:0] cnt;
    logic              tick;

    assign tick      = run && (cnt == half - 1'b1);
    assign rise_tick = tick & ~mdc;
    assign fall_tick = tick & mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the phase counter never runs past the selected half period
    p_half_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < half));

endmodule

// File: rtl/mdio_serdes.sv
module mdio_serdes
    import mdio_mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  is_read,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  last_bit,
    output logic [DATA_BITS-1:0]  rx_data
);
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bitcnt;
    logic                  active;

    assign mdio_o   = active & shreg[FRAME_BITS-1];
    assign mdio_oe  = active && !(is_read && bitcnt >= CNT_W'(TA_BIT));
    assign last_bit = active && (bitcnt == CNT_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bitcnt  <= '0;
            active  <= 1'b0;
            rx_data <= '0;
        end else if (load) begin
            shreg   <= frame;
            bitcnt  <= '0;
            active  <= 1'b1;
            rx_data <= '0;
        end else begin
            if (rise_tick && active && is_read && bitcnt >= CNT_W'(DATA_BIT))
                rx_data <= {rx_data[DATA_BITS-2:0], mdio_i};
            if (fall_tick && active) begin
                if (last_bit) begin
                    active <= 1'b0;
                end else begin
                    shreg  <= shreg << 1;
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    // R7: the bit position only advances on an MDC falling edge
    p_shift_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (!fall_tick && !load) |=> $stable(bitcnt));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic [14:0] cmd_wdata,
    input  logic        data_we,
    input  logic [15:0] data_wdata,
    output logic        busy,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mgmt_cmd_t             cmd_in;
    logic                  busy_q;
    logic                  wr_q;
    logic [CODE_BITS-1:0]  code_q;
    logic [DATA_BITS-1:0]  data_q;
    logic                  accept;
    logic                  done;
    logic                  rise_tick, fall_tick, last_bit;
    logic [DATA_BITS-1:0]  rx_data;
    logic [HALF_W-1:0]     half;

    assign cmd_in = mgmt_cmd_t'(cmd_wdata);
    assign accept = cmd_we && cmd_in.start && !busy_q;
    assign done   = fall_tick && last_bit;
    assign half   = half_period(code_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            code_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            wr_q   <= cmd_in.wr;
            code_q <= cmd_in.range_code;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (done && !wr_q)
            data_q <= rx_data;
        else if (data_we)
            data_q <= data_wdata;
    end

    mdio_clkgen #(.HALF_W(HALF_W)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .run       (busy_q),
        .half      (half),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_serdes u_serdes (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .frame     (build_frame(cmd_in, data_q)),
        .is_read   (!wr_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .last_bit  (last_bit),
        .rx_data   (rx_data)
    );

    assign busy    = busy_q;
    assign rd_data = data_q;

    // R9: idle bus has MDC low and MDIO released
    p_idle_bus_r9: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (!mdc && !mdio_oe));

    // R2: busy holds until the final falling edge of the frame
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> busy_q);

    // R7: MDIO output never moves while MDC is high
    p_mdio_stable_r7: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdio_o));

    // R8: a command issued mid-transaction leaves the running setup alone
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cmd_we) |=> ($stable(code_q) && $stable(wr_q)));

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_we = 1'b0;
    logic [14:0] cmd_wdata = '0;
    logic        data_we = 1'b0;
    logic [15:0] data_wdata = '0;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    always #2 clk = ~clk;   // 250 MHz

    mdio_master u_mdio_master (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .busy(busy),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    typedef struct packed {
        logic [63:0] frame;
        logic [63:0] mask;
        logic [63:0] oe;
        logic [15:0] rd;
        logic [7:0]  ratio;
        logic        wr;
    } exp_t;

    exp_t        expq[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [63:0] phy_frame = '1;
    logic [63:0] cap_o, cap_oe;
    int          cap_idx = 0;
    int          cyc = 0, last_rise = 0, period = 0;
    logic        prev_mdc = 1'b0, prev_busy = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [2:0] code);
        case (code)
            3'd0: return 16;
            3'd1: return 26;
            3'd2: return 42;
            3'd3: return 62;
            default: return 102;
        endcase
    endfunction

    // monitor + PHY model + scoreboard compare
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            cap_idx = 0;
            last_rise = 0;
        end else begin
            if (mdc && !prev_mdc) begin
                if (cap_idx < 64) begin
                    cap_o[63-cap_idx]  = mdio_o;
                    cap_oe[63-cap_idx] = mdio_oe;
                end
                cap_idx++;
                if (last_rise != 0) period = cyc - last_rise;
                last_rise = cyc;
            end
            if (!mdc && prev_mdc && cap_idx < 64)
                mdio_i <= phy_frame[63-cap_idx];
            if (!busy) mdio_i <= 1'b1;
            if (prev_busy && !busy) begin
                if (expq.size() == 0) begin
                    check("R8", "unexpected transaction", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check("R2", "bits per frame", 64'(cap_idx), 64'd64);
                    check("R3", "MDC period", 64'(period), 64'(e.ratio));
                    if (e.wr) begin
                        check("R4", "write frame", cap_o & e.mask, e.frame & e.mask);
                        check("R4", "write drive", cap_oe, e.oe);
                        check("R10", "data after write", 64'(rd_data), 64'(e.rd));
                    end else begin
                        check("R5", "read header", cap_o & e.mask, e.frame & e.mask);
                        check("R5", "read release", cap_oe, e.oe);
                        check("R6", "read result", 64'(rd_data), 64'(e.rd));
                    end
                end
                cap_idx = 0;
                last_rise = 0;
            end
        end
        prev_mdc  = mdc;
        prev_busy = busy;
    end

    // driver: queue expectation, issue command, optionally poke while busy
    task automatic run_txn(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [2:0] code, input logic wr,
                           input logic [15:0] wd, input logic [15:0] rsp,
                           input logic poke);
        exp_t e;
        if (wr) begin
            @(negedge clk); data_we = 1'b1; data_wdata = wd;
            @(negedge clk); data_we = 1'b0;
            check("R10", "data register load", 64'(rd_data), 64'(wd));
        end
        phy_frame   = {48'hFFFF_FFFF_FFFF, rsp};
        e.wr    = wr;
        e.ratio = 8'(ratio_of(code));
        e.frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, wd};
        e.mask  = wr ? '1 : {46'h3FFF_FFFF_FFFF, 18'h0};
        e.oe    = wr ? '1 : {46'h3FFF_FFFF_FFFF, 18'h0};
        e.rd    = wr ? wd : rsp;
        expq.push_back(e);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = {phy, rg, code, wr, 1'b1};
        @(negedge clk); cmd_we = 1'b0;
        check("R2", "busy after start", 64'(busy), 64'd1);
        if (poke) begin
            repeat (300) @(negedge clk);
            cmd_we = 1'b1; cmd_wdata = {~phy, ~rg, ~code, ~wr, 1'b1};
            @(negedge clk); cmd_we = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9", "idle mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset busy", 64'(busy), 64'd0);
        check("R1", "reset mdc", 64'(mdc), 64'd0);
        check("R1", "reset oe", 64'(mdio_oe), 64'd0);
        check("R1", "reset data", 64'(rd_data), 64'd0);

        // command with start clear launches nothing (R2)
        cmd_we = 1'b1; cmd_wdata = {5'd3, 5'd4, 3'd0, 1'b1, 1'b0};
        @(negedge clk); cmd_we = 1'b0;
        repeat (40) @(negedge clk);
        check("R2", "no start without start bit", {62'd0, busy, mdc}, 64'd0);

        run_txn(5'h01, 5'h00, 3'd0, 1'b1, 16'hA5C3, 16'h0000, 1'b0);
        run_txn(5'h1F, 5'h02, 3'd1, 1'b0, 16'h0000, 16'h8001, 1'b0);
        run_txn(5'h0A, 5'h15, 3'd2, 1'b1, 16'h0F0F, 16'h0000, 1'b0);
        run_txn(5'h15, 5'h1F, 3'd3, 1'b0, 16'h0000, 16'h5A69, 1'b0);
        run_txn(5'h00, 5'h11, 3'd4, 1'b1, 16'hFFFE, 16'h0000, 1'b0);
        run_txn(5'h07, 5'h09, 3'd7, 1'b0, 16'h0000, 16'hC0DE, 1'b0);
        // R8: command issued mid-frame must be ignored
        run_txn(5'h12, 5'h05, 3'd0, 1'b0, 16'h0000, 16'h1234, 1'b1);
        run_txn(5'h03, 5'h0C, 3'd1, 1'b1, 16'h4B2D, 16'h0000, 1'b1);
        repeat (2000) @(negedge clk);
        check("R8", "pending expectations", 64'(expq.size()), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule